// File: doc/BRIEF.md
# Processor C-State Clock Controller

This block follows the processor through its three power states (C0 running, C1 halted, C2 stop-clock) and drives the active-low stop-clock request that freezes the instruction stream. A halt report from the processor takes it from C0 to C1. A read strobe on the Level 2 register asserts the stop-clock request and forces C2. A break event wakes the processor. Break events are an unmasked interrupt line, SCI, an NMI source, an SMI source or an INIT source such as a keyboard reset.

All break inputs are combined into one level. That level is registered once before the state machine acts on it, and the same register produces a one-clock break pulse. Leaving C2 takes two steps. First the stop-clock request is released. One clock later the machine chooses C1 or C0: it goes to C1 only when the processor halted while the request was active and the break has already gone away.

The internal states are RUN (C0), HALT (C1), STOP (C2) and RELEASE (C2 encoding, stop-clock released). The named transitions are:
- T_HALT: RUN to HALT.
- T_STOP: RUN or HALT to STOP.
- T_WAKE: HALT to RUN.
- T_RELEASE: STOP to RELEASE.
- T_RESUME_HALT: RELEASE to HALT.
- T_RESUME_RUN: RELEASE to RUN.

Top module: `pstate_clkctl`

## Requirements
- R1: After reset `cstate` is 00 (C0), `stpclk_n` is 1 and `brk_pulse` is 0.
- R2: In C0, `cpu_halt` without `lvl2_rd` (T_HALT) gives `cstate` 01 after the next clock edge.
- R3: `lvl2_rd` in C0 or C1 (T_STOP) gives `cstate` 10 and `stpclk_n` 0 after the next clock edge. It takes priority over `cpu_halt` in C0.
- R4: A break level sampled at edge k while in STOP raises `stpclk_n` at edge k+1 (T_RELEASE). If no condition of R5 applies, `cstate` becomes 00 at edge k+2.
- R5: In RELEASE, if the halt flag is set and the registered break level is low, the next state is C1 (T_RESUME_HALT). Otherwise it is C0 (T_RESUME_RUN).
- R6: In C1, a break level sampled at edge k gives `cstate` 00 at edge k+1 (T_WAKE). Break takes priority over `lvl2_rd`.
- R7: A break is any `irq_line[i]` high with `irq_mask[i]` 0 (mask bit 1 = masked), or any of `sci_evt`, `nmi_evt`, `smi_evt`, `init_evt` high.
- R8: With `irq_wide` 0, only lines 0..15 take part and lines 16..23 are ignored. With `irq_wide` 1, all 24 lines take part.
- R9: `brk_pulse` is high for exactly one clock after the edge at which the combined break level is first sampled high, however long that level is held.
- R10: The `cstate` encoding is 00 = C0, 01 = C1, 10 = C2, and 11 never appears. `lvl2_rd` during C2 has no effect.
- R11: The halt flag clears whenever the state returns to C0. A later C2 episode without a halt then resumes to C0.
- R12: The halt flag is set by `cpu_halt` while in STOP, by T_STOP from C1, and by `cpu_halt` together with `lvl2_rd` in C0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_wide | input | 1 | 1: 24 interrupt lines count, 0: 16 lines |
| cpu_halt | input | 1 | Processor halt report, one-clock strobe |
| lvl2_rd | input | 1 | Level 2 register read strobe |
| irq_line | input | 24 | Interrupt request lines, active high |
| irq_mask | input | 24 | Per-line mask, 1 = masked |
| sci_evt | input | 1 | SCI break source |
| nmi_evt | input | 1 | NMI break source |
| smi_evt | input | 1 | SMI break source |
| init_evt | input | 1 | INIT break source |
| stpclk_n | output | 1 | Stop-clock request, active low |
| cstate | output | 2 | Current C-state encoding |
| brk_pulse | output | 1 | One-clock break-event pulse |

## Verification
The hardest path to reach is T_RESUME_HALT. It needs a halt while the stop-clock request is active, followed by a break that lasts exactly one sampled clock, so that the break register is low again when RELEASE decides. Purely random stimulus rarely lines these up, so directed sequences build the path both ways: through a halt strobe in STOP, and through a combined halt and Level 2 read in C0. Random traffic with short break pulses then mixes these cases with masked lines and mode changes. Every cycle is checked against a bench reference model.

// File: rtl/pstate_pkg.sv
package pstate_pkg;

    // Externally visible C-state encoding
    localparam logic [1:0] CST_C0 = 2'b00;
    localparam logic [1:0] CST_C1 = 2'b01;
    localparam logic [1:0] CST_C2 = 2'b10;

    // Internal controller states
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_HALT    = 2'd1,
        ST_STOP    = 2'd2,
        ST_RELEASE = 2'd3
    } ctl_state_e;

endpackage

// File: rtl/pstate_brk_detect.sv
module pstate_brk_detect #(
    parameter int NUM_IRQ    = 24,
    parameter int NARROW_IRQ = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq_wide,
    input  logic [NUM_IRQ-1:0] irq_line,
    input  logic [NUM_IRQ-1:0] irq_mask,
    input  logic               sci_evt,
    input  logic               nmi_evt,
    input  logic               smi_evt,
    input  logic               init_evt,
    output logic               brk_q,
    output logic               brk_pulse
);
    logic [NUM_IRQ-1:0] line_en;
    logic               brk_lvl;
    logic               brk_d;

    // Lines above the narrow count only take part in wide mode
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_en
        if (i < NARROW_IRQ) begin : g_fixed
            assign line_en[i] = 1'b1;
        end else begin : g_sel
            assign line_en[i] = irq_wide;
        end
    end

    always_comb begin
        brk_lvl = (|(irq_line & ~irq_mask & line_en))
                | sci_evt | nmi_evt | smi_evt | init_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_q <= 1'b0;
            brk_d <= 1'b0;
        end else begin
            brk_q <= brk_lvl;
            brk_d <= brk_q;
        end
    end

    assign brk_pulse = brk_q & ~brk_d;

    // R9: the pulse never lasts two clocks
    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |=> !brk_pulse);

    // R7: a sampled SCI source always registers as a break
    assert_sci_breaks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sci_evt |=> brk_q);

endmodule

// File: rtl/pstate_fsm.sv
module pstate_fsm
    import pstate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_halt,
    input  logic       lvl2_rd,
    input  logic       brk_q,
    output logic       stpclk_n,
    output logic [1:0] cstate
);
    ctl_state_e st_q, st_nx;
    logic       hflag_q, hflag_nx;

    // Next-state and halt-flag logic
    always_comb begin
        st_nx    = st_q;
        hflag_nx = hflag_q;
        unique case (st_q)
            ST_RUN: begin
                hflag_nx = 1'b0;
                if (lvl2_rd) begin
                    st_nx    = ST_STOP;          // T_STOP
                    hflag_nx = cpu_halt;
                end else if (cpu_halt) begin
                    st_nx = ST_HALT;             // T_HALT
                end
            end
            ST_HALT: begin
                if (brk_q) begin
                    st_nx    = ST_RUN;           // T_WAKE
                    hflag_nx = 1'b0;
                end else if (lvl2_rd) begin
                    st_nx    = ST_STOP;          // T_STOP, halt preceded
                    hflag_nx = 1'b1;
                end
            end
            ST_STOP: begin
                if (cpu_halt) hflag_nx = 1'b1;
                if (brk_q) st_nx = ST_RELEASE;   // T_RELEASE
            end
            ST_RELEASE: begin
                hflag_nx = 1'b0;
                if (hflag_q && !brk_q) st_nx = ST_HALT;  // T_RESUME_HALT
                else                   st_nx = ST_RUN;   // T_RESUME_RUN
            end
            default: st_nx = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_RUN;
            hflag_q <= 1'b0;
        end else begin
            st_q    <= st_nx;
            hflag_q <= hflag_nx;
        end
    end

    // Outputs
    always_comb begin
        stpclk_n = 1'b1;
        cstate   = CST_C0;
        unique case (st_q)
            ST_RUN:     cstate = CST_C0;
            ST_HALT:    cstate = CST_C1;
            ST_STOP: begin
                cstate   = CST_C2;
                stpclk_n = 1'b0;
            end
            ST_RELEASE: cstate = CST_C2;
            default:    cstate = CST_C0;
        endcase
    end

    assert_halt_to_c1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cstate == CST_C0 && cpu_halt && !lvl2_rd) |=> cstate == CST_C1);

    assert_l2_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((cstate == CST_C0 || (cstate == CST_C1 && !brk_q)) && lvl2_rd) |=> !stpclk_n);

    assert_break_releases_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!stpclk_n && brk_q) |=> stpclk_n);

    assert_c1_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cstate == CST_C1 && brk_q) |=> cstate == CST_C0);

    assert_legal_enc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cstate != 2'b11);

    assert_l2_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!stpclk_n && !brk_q && lvl2_rd) |=> !stpclk_n);

endmodule

// File: rtl/pstate_clkctl.sv
module pstate_clkctl #(
    parameter int NUM_IRQ    = 24,
    parameter int NARROW_IRQ = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq_wide,
    input  logic               cpu_halt,
    input  logic               lvl2_rd,
    input  logic [NUM_IRQ-1:0] irq_line,
    input  logic [NUM_IRQ-1:0] irq_mask,
    input  logic               sci_evt,
    input  logic               nmi_evt,
    input  logic               smi_evt,
    input  logic               init_evt,
    output logic               stpclk_n,
    output logic [1:0]         cstate,
    output logic               brk_pulse
);
    logic brk_q;

    pstate_brk_detect #(
        .NUM_IRQ    (NUM_IRQ),
        .NARROW_IRQ (NARROW_IRQ)
    ) u_brk (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_wide  (irq_wide),
        .irq_line  (irq_line),
        .irq_mask  (irq_mask),
        .sci_evt   (sci_evt),
        .nmi_evt   (nmi_evt),
        .smi_evt   (smi_evt),
        .init_evt  (init_evt),
        .brk_q     (brk_q),
        .brk_pulse (brk_pulse)
    );

    pstate_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_halt (cpu_halt),
        .lvl2_rd  (lvl2_rd),
        .brk_q    (brk_q),
        .stpclk_n (stpclk_n),
        .cstate   (cstate)
    );

endmodule

// File: tb/pstate_clkctl_bench.sv
module pstate_clkctl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_wide = 1'b1;
    logic        cpu_halt = 1'b0;
    logic        lvl2_rd = 1'b0;
    logic [23:0] irq_line = '0;
    logic [23:0] irq_mask = '1;
    logic        sci_evt = 1'b0, nmi_evt = 1'b0, smi_evt = 1'b0, init_evt = 1'b0;
    logic        stpclk_n, brk_pulse;
    logic [1:0]  cstate;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R1";

    always #4 clk = ~clk;

    pstate_clkctl u_pstate_clkctl (
        .clk(clk), .rst_n(rst_n), .irq_wide(irq_wide), .cpu_halt(cpu_halt),
        .lvl2_rd(lvl2_rd), .irq_line(irq_line), .irq_mask(irq_mask),
        .sci_evt(sci_evt), .nmi_evt(nmi_evt), .smi_evt(smi_evt),
        .init_evt(init_evt), .stpclk_n(stpclk_n), .cstate(cstate),
        .brk_pulse(brk_pulse)
    );

    // Reference model: 0 = C0, 1 = C1, 2 = C2 stop, 3 = C2 released
    int   m_st = 0;
    logic m_flag = 0, m_bq = 0, m_bd = 0;

    function automatic logic f_brk(logic [23:0] ln, logic [23:0] mk, logic wide,
                                   logic s, logic n, logic m, logic i);
        logic [23:0] en;
        en = wide ? 24'hFFFFFF : 24'h00FFFF;
        return (|(ln & ~mk & en)) | s | n | m | i;
    endfunction

    function automatic logic [1:0] f_enc(int st);
        return (st == 0) ? 2'b00 : (st == 1) ? 2'b01 : 2'b10;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_flag = 0; m_bq = 0; m_bd = 0;
        end else begin
            case (m_st)
                0: begin
                    m_flag = 0;
                    if (lvl2_rd) begin m_st = 2; m_flag = cpu_halt; end
                    else if (cpu_halt) m_st = 1;
                end
                1: if (m_bq) m_st = 0;
                   else if (lvl2_rd) begin m_st = 2; m_flag = 1; end
                2: begin
                    if (cpu_halt) m_flag = 1;
                    if (m_bq) m_st = 3;
                end
                default: begin
                    m_st = (m_flag && !m_bq) ? 1 : 0;
                    m_flag = 0;
                end
            endcase
            m_bd = m_bq;
            m_bq = f_brk(irq_line, irq_mask, irq_wide, sci_evt, nmi_evt, smi_evt, init_evt);
        end
    end

    task automatic check(string t, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {cstate,stpclk_n,brk_pulse} actual %b expected %b", t, act, exp);
        end
    endtask

    // Advance one clock with current inputs, compare at the following negedge
    task automatic cyc();
        @(negedge clk);
        check(tag, {cstate, stpclk_n, brk_pulse},
              {f_enc(m_st), (m_st != 2) ? 1'b1 : 1'b0, m_bq & ~m_bd});
    endtask

    task automatic quiet();
        cpu_halt = 0; lvl2_rd = 0; irq_line = '0; sci_evt = 0;
        nmi_evt = 0; smi_evt = 0; init_evt = 0;
    endtask

    task automatic pulse_halt(); cpu_halt = 1; cyc(); cpu_halt = 0; endtask
    task automatic pulse_l2();   lvl2_rd = 1;  cyc(); lvl2_rd = 0;  endtask
    task automatic pulse_sci();  sci_evt = 1;  cyc(); sci_evt = 0;  endtask

    task automatic settle();
        quiet(); repeat (4) cyc();
    endtask

    task automatic expect_state(string t, logic [1:0] e);
        check(t, {2'b00, cstate}, {2'b00, e});
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        tag = "R1";
        check("R1 reset", {cstate, stpclk_n, brk_pulse}, 4'b0010);
        rst_n = 1;
        cyc();

        tag = "R2"; pulse_halt(); expect_state("R2 halt to C1", 2'b01); cyc();
        tag = "R6"; irq_mask = 24'hFFFFF7; irq_line = 24'h000008; cyc(); cyc();
        expect_state("R6 wake from C1", 2'b00);
        tag = "R9"; repeat (3) cyc(); settle();

        tag = "R3"; pulse_l2();
        check("R3 enter C2", {cstate, stpclk_n, 1'b0}, 4'b1000);
        tag = "R10"; pulse_l2(); cyc(); expect_state("R10 L2 in C2 ignored", 2'b10);
        tag = "R4"; pulse_sci(); cyc(); cyc(); expect_state("R4 resume to C0", 2'b00);
        settle();

        tag = "R12"; cpu_halt = 1; lvl2_rd = 1; cyc(); quiet(); cyc();
        tag = "R5"; pulse_sci(); cyc(); cyc(); expect_state("R5 resume to C1", 2'b01);
        settle();

        tag = "R5"; pulse_l2(); pulse_halt(); cyc(); pulse_sci(); cyc(); cyc();
        expect_state("R5 halt in C2 resume to C1", 2'b01);
        settle();

        tag = "R11"; pulse_l2(); pulse_halt(); nmi_evt = 1; repeat (4) cyc();
        expect_state("R11 held break to C0", 2'b00);
        quiet(); cyc(); cyc(); pulse_l2(); cyc(); pulse_sci(); cyc(); cyc();
        expect_state("R11 flag cleared", 2'b00);
        settle();

        tag = "R8"; irq_wide = 0; irq_mask = '0; pulse_halt();
        irq_line = 24'h100000; repeat (3) cyc();
        expect_state("R8 narrow ignores line 20", 2'b01);
        irq_wide = 1; cyc(); cyc(); expect_state("R8 wide line 20 wakes", 2'b00);
        settle();

        tag = "R7"; irq_mask = 24'h000010; pulse_halt(); irq_line = 24'h000010;
        repeat (3) cyc(); expect_state("R7 masked line ignored", 2'b01);
        quiet(); smi_evt = 1; cyc(); cyc(); expect_state("R7 smi wakes", 2'b00);
        settle(); pulse_halt(); init_evt = 1; cyc(); cyc();
        expect_state("R7 init wakes", 2'b00);
        settle();

        tag = "random R4 R5 R7";
        void'($urandom(32'd1234));
        for (int n = 0; n < 20000; n++) begin
            cpu_halt = ($urandom % 6) == 0;
            lvl2_rd  = ($urandom % 7) == 0;
            irq_line = (($urandom % 5) == 0) ? (24'd1 << ($urandom % 24)) : 24'd0;
            if (($urandom % 50) == 0) irq_mask = $urandom;
            if (($urandom % 200) == 0) irq_wide = $urandom;
            sci_evt  = ($urandom % 20) == 0;
            nmi_evt  = ($urandom % 40) == 0;
            smi_evt  = ($urandom % 40) == 0;
            init_evt = ($urandom % 60) == 0;
            cyc();
        end
        quiet(); cyc();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule